// File: doc/BRIEF.md
# SPI Master Byte Shift Engine

This block is the data path of a mode-0 SPI master that streams bytes to and from a sensor. It derives SCK from the system clock by dividing it by ten. With a 50 MHz system clock this gives a 5 MHz bit rate. A single level input opens a transfer. While that input is high, the block holds the slave select low. It shifts command bytes out on MOSI, most significant bit first, and assembles incoming MISO bits into a receive byte.

The block does not sequence commands itself. It gives a surrounding controller two single-cycle, active-low strobes, each at a fixed point of the bit clock. The first strobe pops the next transmit byte from a show-ahead source. The second pushes each completed receive byte into a sink. Two enable inputs gate these strobes. A 16-bit counter tallies completed bytes. The counter is cleared between transfers when the controller signals that the transfer is finished. The controller, the FIFOs and any clock primitives sit outside this block.

Top module: `spi_byte_engine`

## Requirements

Cycle numbering below counts the first cycle in which `ss_n` reads low as cycle 1. Cycle 80k+n then falls in byte k, bit (n mod 80)/10, where bit 0 is the MSB.

- R1: While reset is held, `ss_n`=1, `sck`=0, `mosi`=0, `tx_rd_n`=1, `rx_wr_n`=1 and `byte_count`=0. `ss_n` goes low one cycle after `xfer_en` is sampled high. It returns high one cycle after `xfer_en` is sampled low. `sck` is 0 whenever `ss_n` is 1.
- R2: `sck` has a period of 10 cycles. It is low in the cycles where n mod 10 is 0 to 4 and high where n mod 10 is 5 to 9, so the first high cycle is cycle 5.
- R3: MOSI carries each byte MSB first. Bit j of byte k is held on `mosi` through every high cycle of bit period 8k+j. `mosi` never changes in a cycle where `sck` is high. Consecutive bytes follow with no idle bit between them.
- R4: `tx_rd_n` is low for exactly one cycle, in cycles 80k+1. The byte on `tx_byte` is captured on the edge that drives the strobe low. With `send_en` low, no strobe is issued and the byte sent is 0x00.
- R5: MISO is sampled on the system clock edge that drives `sck` high. The first bit sampled ends in `rx_byte[7]` and the eighth ends in `rx_byte[0]`. The assembled byte stays on `rx_byte` until the next byte's first sample, whether or not `recv_en` is high.
- R6: `rx_wr_n` is low for exactly one cycle, in cycles 80k+77. That is two cycles after `sck` goes high for the eighth time in the byte. The strobe is issued only while `recv_en` is high.
- R7: `byte_count` increases by one in cycles 80k+77, whatever `send_en` and `recv_en` are.
- R8: `byte_count` clears to 0 on an edge where `xfer_en` is low and `xfer_done` is high. While `xfer_en` is high, `xfer_done` has no effect. While `xfer_en` is low and `xfer_done` is low, the count holds.
- R9: Dropping `xfer_en` in the middle of a byte abandons that byte: neither strobe fires for it and it is not counted. The next transfer restarts at bit 0 with the timing of R2 to R4.
- R10: `tx_rd_n` and `rx_wr_n` are never low in the same cycle.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (50 MHz nominal) |
| rst | input | 1 | Synchronous active-high reset |
| xfer_en | input | 1 | Transfer active level; low holds the bit clock at its start point |
| send_en | input | 1 | Allows transmit-byte pops and MOSI data |
| recv_en | input | 1 | Allows receive-byte push strobes |
| xfer_done | input | 1 | Clears the byte counter while no transfer is active |
| tx_byte | input | 8 | Show-ahead next transmit byte |
| miso | input | 1 | Serial data from the slave |
| sck | output | 1 | Serial clock, idles low |
| ss_n | output | 1 | Slave select, active low |
| mosi | output | 1 | Serial data to the slave |
| tx_rd_n | output | 1 | Active-low pop strobe for the transmit source |
| rx_wr_n | output | 1 | Active-low push strobe for the received byte |
| rx_byte | output | 8 | Receive shift register contents |
| byte_count | output | 16 | Completed bytes in the current transfer |

## Verification

The assertions assume the following about the inputs:

- `xfer_en` is held as a level for whole stretches of cycles.
- `send_en` and `recv_en` change only while no transfer is active.
- `tx_byte` already shows the next byte when the pop strobe falls.
- `miso` changes only while `sck` is low.

The bench meets these assumptions with a behavioural slave. The slave updates `miso` only on observed SCK falling edges and reloads only after eight rising edges. The enables are switched only between transfers, and the transmit source advances only after it sees `tx_rd_n` low.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

  // Per-cycle events decoded from the bit clock position.
  typedef struct packed {
    logic load;    // first edge of a byte: capture the next transmit byte
    logic shift;   // last phase of a bit: advance the transmit register
    logic sample;  // edge that raises SCK: take one MISO bit
    logic done;    // fixed phase in the last bit: byte is complete
  } spi_tick_t;

endpackage

// File: rtl/spi_eng_timer.sv
module spi_eng_timer
  import spi_eng_pkg::*;
#(
  parameter int DIV      = 10,
  parameter int BITS     = 8,
  parameter int WR_PHASE = 6
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      xfer_en,
  output spi_tick_t tick,
  output logic      sck,
  output logic      ss_n
);

  localparam int PH_W = $clog2(DIV);
  localparam int BC_W = $clog2(BITS);
  localparam int HALF = DIV / 2;

  logic [PH_W-1:0] phase;
  logic [BC_W-1:0] bitc;

  always_ff @(posedge clk) begin
    if (rst || !xfer_en) begin
      phase <= '0;
      bitc  <= '0;
    end else begin
      if (phase == PH_W'(DIV - 1)) begin
        phase <= '0;
        bitc  <= (bitc == BC_W'(BITS - 1)) ? '0 : bitc + 1'b1;
      end else begin
        phase <= phase + 1'b1;
      end
    end
  end

  // SCK is registered one phase ahead, so it is high while phase is HALF..DIV-1.
  always_ff @(posedge clk) begin
    if (rst) begin
      sck  <= 1'b0;
      ss_n <= 1'b1;
    end else begin
      sck  <= xfer_en && (phase >= PH_W'(HALF - 1)) && (phase <= PH_W'(DIV - 2));
      ss_n <= !xfer_en;
    end
  end

  always_comb begin
    tick.load   = xfer_en && (phase == '0) && (bitc == '0);
    tick.shift  = xfer_en && (phase == PH_W'(DIV - 1));
    tick.sample = xfer_en && (phase == PH_W'(HALF - 1));
    tick.done   = xfer_en && (phase == PH_W'(WR_PHASE)) && (bitc == BC_W'(BITS - 1));
  end

endmodule

// File: rtl/spi_eng_tx.sv
module spi_eng_tx #(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic            shift,
  input  logic            send_en,
  input  logic [BITS-1:0] tx_byte,
  output logic            mosi,
  output logic            tx_rd_n
);

  logic [BITS-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh      <= '0;
      tx_rd_n <= 1'b1;
    end else begin
      tx_rd_n <= !(load && send_en);
      if (load)
        sh <= send_en ? tx_byte : '0;
      else if (shift)
        sh <= {sh[BITS-2:0], 1'b0};
    end
  end

  assign mosi = sh[BITS-1];

endmodule

// File: rtl/spi_eng_rx.sv
module spi_eng_rx #(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sample,
  input  logic            done,
  input  logic            recv_en,
  input  logic            miso,
  output logic [BITS-1:0] rx_byte,
  output logic            rx_wr_n
);

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_byte <= '0;
      rx_wr_n <= 1'b1;
    end else begin
      rx_wr_n <= !(done && recv_en);
      if (sample)
        rx_byte <= {rx_byte[BITS-2:0], miso};
    end
  end

endmodule

// File: rtl/spi_eng_count.sv
module spi_eng_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             done,
  input  logic             xfer_en,
  input  logic             xfer_done,
  output logic [CNT_W-1:0] byte_count
);

  always_ff @(posedge clk) begin
    if (rst || (!xfer_en && xfer_done))
      byte_count <= '0;
    else if (done)
      byte_count <= byte_count + 1'b1;
  end

endmodule

// File: rtl/spi_byte_engine.sv
module spi_byte_engine
  import spi_eng_pkg::*;
#(
  parameter int CLK_DIV  = 10,
  parameter int BYTE_W   = 8,
  parameter int CNT_W    = 16,
  parameter int WR_PHASE = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              xfer_en,
  input  logic              send_en,
  input  logic              recv_en,
  input  logic              xfer_done,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic              miso,
  output logic              sck,
  output logic              ss_n,
  output logic              mosi,
  output logic              tx_rd_n,
  output logic              rx_wr_n,
  output logic [BYTE_W-1:0] rx_byte,
  output logic [CNT_W-1:0]  byte_count
);

  spi_tick_t tick;

  spi_eng_timer #(.DIV(CLK_DIV), .BITS(BYTE_W), .WR_PHASE(WR_PHASE)) u_timer (
    .clk(clk), .rst(rst), .xfer_en(xfer_en), .tick(tick), .sck(sck), .ss_n(ss_n)
  );

  spi_eng_tx #(.BITS(BYTE_W)) u_tx (
    .clk(clk), .rst(rst), .load(tick.load), .shift(tick.shift), .send_en(send_en),
    .tx_byte(tx_byte), .mosi(mosi), .tx_rd_n(tx_rd_n)
  );

  spi_eng_rx #(.BITS(BYTE_W)) u_rx (
    .clk(clk), .rst(rst), .sample(tick.sample), .done(tick.done), .recv_en(recv_en),
    .miso(miso), .rx_byte(rx_byte), .rx_wr_n(rx_wr_n)
  );

  spi_eng_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst(rst), .done(tick.done), .xfer_en(xfer_en), .xfer_done(xfer_done),
    .byte_count(byte_count)
  );

endmodule

// File: rtl/spi_byte_engine_chk.sv
module spi_byte_engine_chk #(
  parameter int DIV   = 10,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             xfer_en,
  input logic             sck,
  input logic             ss_n,
  input logic             mosi,
  input logic             tx_rd_n,
  input logic             rx_wr_n,
  input logic [CNT_W-1:0] byte_count
);

  localparam int PC_W = $clog2(DIV) + 2;

  logic            past_ok;
  logic            sck_d;
  logic [PC_W-1:0] per_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      past_ok <= 1'b0;
      sck_d   <= 1'b0;
    end else begin
      past_ok <= 1'b1;
      sck_d   <= sck;
    end
  end

  // Cycles since the last SCK rise within one continuous selection.
  always_ff @(posedge clk) begin
    if (rst || ss_n)
      per_cnt <= '0;
    else if (sck && !sck_d)
      per_cnt <= PC_W'(1);
    else if (per_cnt != '0 && per_cnt != '1)
      per_cnt <= per_cnt + 1'b1;
  end

  assert_idle_sck_low_R1: assert property (@(posedge clk) disable iff (rst)
    ss_n |-> !sck);

  assert_select_follows_en_R1: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> (ss_n == !$past(xfer_en)));

  assert_sck_period_R2: assert property (@(posedge clk) disable iff (rst)
    (sck && !sck_d && per_cnt != '0) |-> (per_cnt == PC_W'(DIV)));

  assert_mosi_steady_high_R3: assert property (@(posedge clk) disable iff (rst)
    (past_ok && sck) |-> $stable(mosi));

  assert_tx_pulse_single_R4: assert property (@(posedge clk) disable iff (rst)
    !tx_rd_n |=> tx_rd_n);

  assert_rx_pulse_single_R6: assert property (@(posedge clk) disable iff (rst)
    !rx_wr_n |=> rx_wr_n);

  assert_count_with_push_R7: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $fell(rx_wr_n)) |-> (byte_count - $past(byte_count) == CNT_W'(1)));

  assert_count_steps_R8: assert property (@(posedge clk) disable iff (rst)
    (past_ok && byte_count != $past(byte_count)) |->
      (byte_count == '0 || byte_count - $past(byte_count) == CNT_W'(1)));

  assert_strobes_apart_R10: assert property (@(posedge clk) disable iff (rst)
    !(!tx_rd_n && !rx_wr_n));

endmodule

bind spi_byte_engine spi_byte_engine_chk #(.DIV(CLK_DIV), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/spi_byte_engine_test.sv
module spi_byte_engine_test;

  localparam int CLK_PERIOD = 20;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          xfer_en = 1'b0;
  logic          send_en = 1'b1;
  logic          recv_en = 1'b1;
  logic          xfer_done = 1'b0;
  logic [7:0]    tx_byte = 8'hC3;
  logic          miso = 1'b0;
  logic          sck, ss_n, mosi, tx_rd_n, rx_wr_n;
  logic [7:0]    rx_byte;
  logic [CW-1:0] byte_count;

  spi_byte_engine uut (
    .clk(clk), .rst(rst), .xfer_en(xfer_en), .send_en(send_en), .recv_en(recv_en),
    .xfer_done(xfer_done), .tx_byte(tx_byte), .miso(miso), .sck(sck), .ss_n(ss_n),
    .mosi(mosi), .tx_rd_n(tx_rd_n), .rx_wr_n(rx_wr_n), .rx_byte(rx_byte),
    .byte_count(byte_count)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_vec = 0;
  int n_bad = 0;

  task automatic check(string tag, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] tx_pat(int k);
    return 8'((k * 91) ^ 8'hC3);
  endfunction

  function automatic logic [7:0] sl_pat(int k);
    return 8'((k * 37) ^ 8'h5A);
  endfunction

  // Scoreboard state
  logic [7:0] exp_tx_q[$];
  logic [7:0] exp_rx_q[$];
  int   tx_seq = 0, sl_seq = 0;
  int   n_txs = 0, n_rxs = 0, n_ovl = 0, n_hichg = 0;
  int   mon_bits = 0, sl_bits = 0;
  logic [7:0] mon_sh = 8'h00, sl_cur = 8'h00, sl_last = 8'h00;
  logic prev_sck = 1'b0, prev_ss_n = 1'b1, prev_mosi = 1'b0;

  // Driver of tx_byte and miso, and monitor of mosi and rx_byte.
  always @(negedge clk) begin
    if (!rst) begin
      if (!tx_rd_n && !rx_wr_n) n_ovl++;
      if (sck && (mosi !== prev_mosi)) n_hichg++;
      if (ss_n) begin
        exp_tx_q.delete();
        exp_rx_q.delete();
        mon_bits = 0;
        sl_bits  = 0;
        miso     = 1'b0;
      end else begin
        if (prev_ss_n) begin
          sl_cur = sl_pat(sl_seq);
          sl_seq++;
          if (recv_en) exp_rx_q.push_back(sl_cur);
          sl_bits = 0;
          miso    = sl_cur[7];
        end
        if (!tx_rd_n) begin
          n_txs++;
          exp_tx_q.push_back(tx_byte);
          tx_seq++;
          tx_byte = tx_pat(tx_seq);
        end
        if (sck && !prev_sck) begin
          mon_sh = {mon_sh[6:0], mosi};
          mon_bits++;
          sl_bits++;
          if (sl_bits == 8) sl_last = sl_cur;
          if (mon_bits == 8) begin
            logic [7:0] e;
            e = (exp_tx_q.size() == 0) ? 8'h00 : exp_tx_q.pop_front();
            check("R3/R4 mosi byte", int'(mon_sh), int'(e));
            mon_bits = 0;
          end
        end
        if (!sck && prev_sck) begin
          if (sl_bits == 8) begin
            sl_cur = sl_pat(sl_seq);
            sl_seq++;
            if (recv_en) exp_rx_q.push_back(sl_cur);
            sl_bits = 0;
            miso    = sl_cur[7];
          end else begin
            miso = sl_cur[3'(7 - sl_bits)];
          end
        end
        if (!rx_wr_n) begin
          int e;
          n_rxs++;
          e = (exp_rx_q.size() == 0) ? -1 : int'(exp_rx_q.pop_front());
          check("R5/R6 rx byte", int'(rx_byte), e);
        end
      end
    end
    prev_sck  = sck;
    prev_ss_n = ss_n;
    prev_mosi = mosi;
  end

  task automatic run_bytes(int n);
    logic [CW-1:0] tgt;
    tgt = byte_count + CW'(n);
    xfer_en = 1'b1;
    while (byte_count != tgt) @(negedge clk);
    xfer_en = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog R9 actual=100000 cycles expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int e_ss, e_sck, e_tx, e_rx, e_cnt, e_mosi, k0, s0, q0, c0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check("R1 reset ss_n", int'(ss_n), 1);
    check("R1 reset sck", int'(sck), 0);
    check("R1 reset mosi", int'(mosi), 0);
    check("R1 reset tx_rd_n", int'(tx_rd_n), 1);
    check("R1 reset rx_wr_n", int'(rx_wr_n), 1);
    check("R1 reset byte_count", int'(byte_count), 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // Cycle-exact timing over three back-to-back bytes (R1-R4, R6, R7)
    e_ss = 0; e_sck = 0; e_tx = 0; e_rx = 0; e_cnt = 0; e_mosi = 0;
    k0 = tx_seq;
    xfer_en = 1'b1;
    for (int c = 1; c <= 237; c++) begin
      logic [7:0] eb;
      @(negedge clk);
      if (ss_n !== 1'b0) e_ss++;
      if (sck !== ((c % 10) >= 5)) e_sck++;
      if (tx_rd_n !== ((c % 80) != 1)) e_tx++;
      if (rx_wr_n !== ((c % 80) != 77)) e_rx++;
      if (int'(byte_count) != (c + 3) / 80) e_cnt++;
      if ((c % 10) >= 5) begin
        eb = tx_pat(k0 + c / 80);
        if (mosi !== eb[3'(7 - (c % 80) / 10)]) e_mosi++;
      end
      if (c == 237) xfer_en = 1'b0;
    end
    check("R1 ss_n low throughout transfer", e_ss, 0);
    check("R2 sck phase per cycle", e_sck, 0);
    check("R3 mosi bit per sck-high cycle", e_mosi, 0);
    check("R4 tx_rd_n strobe cycles", e_tx, 0);
    check("R6 rx_wr_n strobe cycles", e_rx, 0);
    check("R7 byte_count per cycle", e_cnt, 0);
    @(negedge clk);
    check("R1 ss_n high after xfer_en low", int'(ss_n), 1);
    check("R1 sck low when deselected", int'(sck), 0);

    // R8 hold while idle, then clear
    repeat (5) @(negedge clk);
    check("R8 count holds while idle", int'(byte_count), 3);
    xfer_done = 1'b1;
    @(negedge clk);
    xfer_done = 1'b0;
    check("R8 count cleared by xfer_done", int'(byte_count), 0);

    // R4 send disabled: no pops, zero bytes on mosi
    send_en = 1'b0;
    s0 = n_txs; q0 = tx_seq;
    run_bytes(2);
    check("R4 no pop strobe with send_en low", n_txs, s0);
    check("R4 source not advanced with send_en low", tx_seq, q0);
    check("R7 count with send_en low", int'(byte_count), 2);
    send_en = 1'b1;
    @(negedge clk);

    // R6 receive disabled: no push, count and rx_byte still advance
    recv_en = 1'b0;
    s0 = n_rxs; c0 = int'(byte_count);
    run_bytes(2);
    check("R6 no push strobe with recv_en low", n_rxs, s0);
    check("R7 count with recv_en low", int'(byte_count), c0 + 2);
    check("R5 rx_byte assembled with recv_en low", int'(rx_byte), int'(sl_last));
    recv_en = 1'b1;
    @(negedge clk);

    // R9 abort mid-byte then restart
    c0 = int'(byte_count);
    s0 = n_rxs;
    xfer_en = 1'b1;
    repeat (35) @(negedge clk);
    xfer_en = 1'b0;
    @(negedge clk);
    check("R9 deselect on abort", int'(ss_n), 1);
    check("R9 partial byte not counted", int'(byte_count), c0);
    check("R9 partial byte not pushed", n_rxs, s0);
    repeat (3) @(negedge clk);
    xfer_en = 1'b1;
    @(negedge clk);
    check("R9 restart pops in cycle 1", int'(tx_rd_n), 0);
    while (int'(byte_count) != c0 + 1) @(negedge clk);
    xfer_en = 1'b0;
    @(negedge clk);
    check("R9 restart byte pushed", n_rxs, s0 + 1);

    // R8 xfer_done ignored while active, clears once idle
    c0 = int'(byte_count);
    xfer_done = 1'b1;
    xfer_en = 1'b1;
    repeat (170) @(negedge clk);
    check("R8 xfer_done ignored while active", int'(byte_count), c0 + 2);
    xfer_en = 1'b0;
    @(negedge clk);
    check("R8 clear once idle", int'(byte_count), 0);
    xfer_done = 1'b0;
    @(negedge clk);

    // Long stream through the scoreboard
    s0 = n_rxs;
    run_bytes(30);
    check("R6 pushes across stream", n_rxs, s0 + 30);
    check("R7 count after stream", int'(byte_count), 30);
    check("R10 strobes never overlap", n_ovl, 0);
    check("R3 mosi changed while sck high", n_hichg, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule